// File: doc/BRIEF.md
# NAND Sector Hamming Parity Generator

This block builds a single-error-correcting Hamming code for one NAND sector while the sector's data crosses the flash data bus. Each accepted data beat adds its contribution to two sets of parity bits. One set follows the bit position inside a byte. The other set follows the byte's address within the sector. Every parity is held as a pair: the "even" member covers positions whose selecting address bit is 0, and the "odd" member covers positions where it is 1. The code is stored without inversion.

Software programs three write-only registers over a simple write port. It turns accumulation on, chooses an 8-bit or 16-bit column width and names the chip select being watched. It sets the sector length and clears the parity before each sector. When the programmed number of beats has been taken, the block raises a done flag. It then freezes a 32-bit result word and a packed three-byte code, which the controller can write to or compare against the spare area. The block corrects nothing and produces no flash timing.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset the result, the packed code and the done flag are all zero. Accumulation is off, the width is 8-bit, the watched chip select is 0 and the sector length is 512 bytes (size field 255).
- R2: A beat counts only when `data_valid` is high, accumulation is on (config bit 0), and `data_cs` equals the config chip-select field at bits [3:1]. Any other beat leaves the result unchanged.
- R3: Pair index 0 (weight 1) covers bits 0,2,4,6 (even) and 1,3,5,7 (odd) of each byte. Index 1 (weight 2) covers bits 0,1,4,5 and 2,3,6,7. Index 2 (weight 4) covers bits 0..3 and 4..7.
- R4: Pair index 3+k (weights 8 to 2048, k = 0..8) holds the parity of all bytes whose byte address has bit k equal to 0 (even) or 1 (odd).
- R5: `result_o[11:0]` holds the even members and `result_o[27:16]` the odd members, in ascending weight. Bits [15:12] and [31:28] read 0.
- R6: `code_o[7:0]` = result[7:0], `code_o[15:8]` = result[23:16], `code_o[19:16]` = result[11:8], `code_o[23:20]` = result[27:24].
- R7: The code is not inverted. A whole sector of 0xFF bytes yields a zero code.
- R8: The size register (register address 2) holds N in bits [31:22]. A sector is 2*(N+1) bytes. `done_o` rises on the cycle after the last counted beat.
- R9: Config bit 7 selects 16-bit beats. A beat counts as two bytes: `data_in[7:0]` at even byte address 2w, `data_in[15:8]` at 2w+1. In 8-bit mode `data_in[15:8]` is ignored.
- R10: Once done, further beats are ignored and the result holds until a clear.
- R11: A write to the control register (address 0) with bit 8 set zeroes the parity and the beat count. Without bit 8 such a write changes nothing. Register address 1 is config.
- R12: A counted beat shows in `result_o` and `code_o` one clock after the edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 config, 2 size |
| reg_wdata | input | 32 | Register write data |
| data_valid | input | 1 | Data beat present on the flash bus |
| data_cs | input | CS_W | Chip select of the current beat |
| data_in | input | 16 | Flash bus data |
| result_o | output | 32 | Even/odd parity pairs |
| code_o | output | 24 | Packed three-byte code |
| done_o | output | 1 | Sector length reached |

## Verification
The parity and the done flag are registered, so a beat that the bench drives at a falling edge is taken at the next rising edge. Its effect on `result_o`, `code_o` and `done_o` is sampled at the falling edge after that, one cycle later. Register writes follow the same rule: a clear is checked one falling edge after its strobe. Sectors are streamed with random idle gaps, and the bench compares only after the stream has ended. It also samples `done_o` just before the final beat, to show the flag rises no earlier than that beat.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_CFG  = 2'd1,
        REG_SIZE = 2'd2,
        REG_NONE = 2'd3
    } ecc_reg_e;

    localparam int CLR_BIT  = 8;
    localparam int EN_BIT   = 0;
    localparam int CS_LSB   = 1;
    localparam int WIDE_BIT = 7;
    localparam int SIZE_LSB = 22;
    localparam int ODD_LSB  = 16;
    localparam int POS_PAIRS = 3;
endpackage

// File: rtl/nand_ecc_lane.sv
module nand_ecc_lane #(
    parameter int ADDR_BITS = 9,
    localparam int NP = nand_ecc_pkg::POS_PAIRS + ADDR_BITS
) (
    input  logic [7:0]           byte_i,
    input  logic [ADDR_BITS-1:0] addr_i,
    output logic [NP-1:0]        even_o,
    output logic [NP-1:0]        odd_o
);
    logic par;

    always_comb begin
        par = ^byte_i;
        even_o[0] = ^(byte_i & 8'h55);
        odd_o[0]  = ^(byte_i & 8'hAA);
        even_o[1] = ^(byte_i & 8'h33);
        odd_o[1]  = ^(byte_i & 8'hCC);
        even_o[2] = ^(byte_i & 8'h0F);
        odd_o[2]  = ^(byte_i & 8'hF0);
    end

    for (genvar k = 0; k < ADDR_BITS; k++) begin : g_addr
        assign even_o[nand_ecc_pkg::POS_PAIRS+k] = par & ~addr_i[k];
        assign odd_o[nand_ecc_pkg::POS_PAIRS+k]  = par &  addr_i[k];
    end
endmodule

// File: rtl/nand_ecc_pack.sv
module nand_ecc_pack #(
    parameter int NP = 12
) (
    input  logic [NP-1:0] pe_i,
    input  logic [NP-1:0] po_i,
    output logic [31:0]   result_o,
    output logic [23:0]   code_o
);
    always_comb begin
        result_o = '0;
        result_o[NP-1:0] = pe_i;
        result_o[nand_ecc_pkg::ODD_LSB +: NP] = po_i;
        code_o = {result_o[27:24], result_o[11:8], result_o[23:16], result_o[7:0]};
    end
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen #(
    parameter int SIZE_W    = 10,
    parameter int CS_W      = 3,
    parameter int ADDR_BITS = 9,
    parameter int DEF_SIZE  = 255
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    input  logic            data_valid,
    input  logic [CS_W-1:0] data_cs,
    input  logic [15:0]     data_in,
    output logic [31:0]     result_o,
    output logic [23:0]     code_o,
    output logic            done_o
);
    import nand_ecc_pkg::*;

    localparam int NP    = POS_PAIRS + ADDR_BITS;
    localparam int CNT_W = SIZE_W + 2;
    localparam int LANES = 2;

    typedef struct packed {
        logic              en;
        logic              wide;
        logic [CS_W-1:0]   cs;
        logic [SIZE_W-1:0] size;
        logic [CNT_W-1:0]  cnt;
        logic [NP-1:0]     pe;
        logic [NP-1:0]     po;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_BITS-1:0] lane_addr [LANES];
    logic [NP-1:0]        lane_e    [LANES];
    logic [NP-1:0]        lane_o    [LANES];
    logic [CNT_W-1:0]     limit;
    logic                 take;
    logic                 unused_ok;

    assign unused_ok = ^{reg_wdata[SIZE_LSB-1:CLR_BIT+1], reg_wdata[WIDE_BIT-1:CS_LSB+CS_W]};

    always_comb begin
        lane_addr[0] = st_q.wide ? {st_q.cnt[ADDR_BITS-2:0], 1'b0} : st_q.cnt[ADDR_BITS-1:0];
        lane_addr[1] = {st_q.cnt[ADDR_BITS-2:0], 1'b1};
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        nand_ecc_lane #(.ADDR_BITS(ADDR_BITS)) u_lane (
            .byte_i (data_in[8*l +: 8]),
            .addr_i (lane_addr[l]),
            .even_o (lane_e[l]),
            .odd_o  (lane_o[l])
        );
    end

    always_comb begin
        st_d  = st_q;
        limit = st_q.wide ? (CNT_W'(st_q.size) + CNT_W'(1))
                          : ({1'b0, st_q.size, 1'b0} + CNT_W'(2));
        done_o = (st_q.cnt >= limit);
        take   = st_q.en && data_valid && (data_cs == st_q.cs) && !done_o;

        if (take) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            st_d.pe  = st_q.pe ^ lane_e[0] ^ (st_q.wide ? lane_e[1] : '0);
            st_d.po  = st_q.po ^ lane_o[0] ^ (st_q.wide ? lane_o[1] : '0);
        end

        if (reg_wr) begin
            unique case (ecc_reg_e'(reg_addr))
                REG_CTRL: if (reg_wdata[CLR_BIT]) begin
                    st_d.cnt = '0;
                    st_d.pe  = '0;
                    st_d.po  = '0;
                end
                REG_CFG: begin
                    st_d.en   = reg_wdata[EN_BIT];
                    st_d.wide = reg_wdata[WIDE_BIT];
                    st_d.cs   = reg_wdata[CS_LSB +: CS_W];
                end
                REG_SIZE: st_d.size = reg_wdata[SIZE_LSB +: SIZE_W];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.size <= SIZE_W'(DEF_SIZE);
        end else begin
            st_q <= st_d;
        end
    end

    nand_ecc_pack #(.NP(NP)) u_pack (
        .pe_i     (st_q.pe),
        .po_i     (st_q.po),
        .result_o (result_o),
        .code_o   (code_o)
    );
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clr_i,
    input logic        reg_wr,
    input logic        data_valid,
    input logic        en_q,
    input logic [31:0] result_o,
    input logic        done_o
);
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (result_o == 32'h0) && !done_o); // R11

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr_i) |=> $stable(result_o)); // R10

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !reg_wr) |=> done_o); // R8

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !clr_i) |=> $stable(result_o)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_valid && !clr_i) |=> $stable(result_o)); // R2

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (result_o[15:12] == 4'h0) && (result_o[31:28] == 4'h0)); // R5
endmodule

bind nand_ecc_gen nand_ecc_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (reg_wr && (reg_addr == 2'd0) && reg_wdata[8]),
    .reg_wr     (reg_wr),
    .data_valid (data_valid),
    .en_q       (st_q.en),
    .result_o   (result_o),
    .done_o     (done_o)
);

// File: tb/nand_ecc_gen_tb.sv
module nand_ecc_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic        data_valid = 1'b0;
    logic [2:0]  data_cs = 3'd0;
    logic [15:0] data_in = 16'h0;
    logic [31:0] result_o;
    logic [23:0] code_o;
    logic        done_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [11:0] exp_e, exp_o;
    logic [7:0]  sect [0:511];
    int unsigned seed_val;

    always #2.5 clk = ~clk;

    nand_ecc_gen u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .data_valid(data_valid), .data_cs(data_cs),
        .data_in(data_in), .result_o(result_o), .code_o(code_o), .done_o(done_o)
    );

    function automatic logic [23:0] ref_term(input logic [7:0] b, input int addr);
        logic [11:0] e, o;
        e = '0; o = '0;
        for (int j = 0; j < 8; j++) begin
            if (b[j]) begin
                for (int k = 0; k < 3; k++)
                    if ((j >> k) & 1) o[k] = ~o[k]; else e[k] = ~e[k];
                for (int k = 0; k < 9; k++)
                    if ((addr >> k) & 1) o[3+k] = ~o[3+k]; else e[3+k] = ~e[3+k];
            end
        end
        return {o, e};
    endfunction

    function automatic logic [31:0] exp_result();
        return {4'h0, exp_o, 4'h0, exp_e};
    endfunction

    function automatic logic [23:0] exp_code();
        return {exp_o[11:8], exp_e[11:8], exp_o[7:0], exp_e[7:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'h0;
    endtask

    task automatic set_cfg(input bit en, input bit wide, input int cs);
        wr(2'd1, (32'(en)) | (32'(cs) << 1) | (32'(wide) << 7));
    endtask

    task automatic clear_model();
        exp_e = '0; exp_o = '0;
    endtask

    // Drives beats [first, first+count); updates model when upd is set.
    task automatic send(input int first, input int count, input bit wide,
                        input int cs, input bit upd);
        logic [23:0] t;
        for (int i = first; i < first + count; i++) begin
            @(negedge clk);
            if (($urandom(seed_val) & 3) == 0) begin
                data_valid = 1'b0;
                @(negedge clk);
            end
            data_valid = 1'b1;
            data_cs = 3'(cs);
            if (wide) begin
                data_in = {sect[(2*i+1) % 512], sect[(2*i) % 512]};
                t = ref_term(sect[(2*i) % 512], 2*i) ^ ref_term(sect[(2*i+1) % 512], 2*i+1);
            end else begin
                data_in = {8'($urandom(seed_val)), sect[i % 512]};
                t = ref_term(sect[i % 512], i);
            end
            if (upd) begin
                exp_e ^= t[11:0];
                exp_o ^= t[23:12];
            end
        end
        @(negedge clk);
        data_valid = 1'b0;
    endtask

    task automatic fill_random();
        for (int i = 0; i < 512; i++) sect[i] = 8'($urandom(seed_val));
    endtask

    task automatic do_clear();
        wr(2'd0, 32'h101);
        clear_model();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        seed_val = 32'd1234;
        void'($urandom(seed_val));
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 result", result_o, 32'h0);
        check("R1 code", {8'h0, code_o}, 32'h0);
        check("R1 done", {31'h0, done_o}, 32'h0);

        // Disabled after reset: beats ignored (R2)
        fill_random();
        send(0, 4, 1'b0, 0, 1'b0);
        check("R2 disabled", result_o, 32'h0);

        // Single beat latency and bit/address mapping (R12, R3, R4)
        set_cfg(1'b1, 1'b0, 0);
        @(negedge clk);
        data_valid = 1'b1; data_cs = 3'd0; data_in = 16'hA501;
        @(negedge clk);
        data_valid = 1'b0;
        check("R12 R3 R4 one beat", result_o, 32'h0000_0FFF);
        check("R6 one beat code", {8'h0, code_o}, 32'h000F_00FF);

        // Control write without clear bit (R11)
        wr(2'd0, 32'h1);
        check("R11 no clear", result_o, 32'h0000_0FFF);
        do_clear();
        check("R11 clear", result_o, 32'h0);

        // Full 0xFF sector, default size 512 bytes (R7, R8)
        for (int i = 0; i < 512; i++) sect[i] = 8'hFF;
        send(0, 511, 1'b0, 0, 1'b1);
        check("R8 not done early", {31'h0, done_o}, 32'h0);
        send(511, 1, 1'b0, 0, 1'b1);
        check("R8 done", {31'h0, done_o}, 32'h1);
        check("R7 erased code", {8'h0, code_o}, 32'h0);

        // Extra beats after done ignored (R10)
        fill_random();
        send(0, 5, 1'b0, 0, 1'b0);
        check("R10 hold", result_o, exp_result());

        // Random 8-bit sectors, some with one flipped bit (R3 R4 R5 R6)
        for (int s = 0; s < 4; s++) begin
            do_clear();
            fill_random();
            if (s >= 2) sect[$urandom(seed_val) % 512] ^= 8'(1 << ($urandom(seed_val) % 8));
            send(0, 512, 1'b0, 0, 1'b1);
            check("R3 R4 R5 result", result_o, exp_result());
            check("R6 code", {8'h0, code_o}, {8'h0, exp_code()});
        end

        // Chip-select filter (R2)
        do_clear();
        set_cfg(1'b1, 1'b0, 5);
        fill_random();
        send(0, 6, 1'b0, 2, 1'b0);
        check("R2 wrong cs", result_o, 32'h0);
        send(0, 6, 1'b0, 5, 1'b1);
        check("R2 matching cs", result_o, exp_result());

        // Small 8-bit sector: N=3 -> 8 bytes (R8)
        do_clear();
        wr(2'd2, 32'd3 << 22);
        send(0, 7, 1'b0, 5, 1'b1);
        check("R8 small not done", {31'h0, done_o}, 32'h0);
        send(7, 1, 1'b0, 5, 1'b1);
        check("R8 small done", {31'h0, done_o}, 32'h1);
        check("R8 small result", result_o, exp_result());

        // 16-bit mode: N=31 -> 64 bytes, 32 words (R9, R8)
        do_clear();
        set_cfg(1'b1, 1'b1, 0);
        wr(2'd2, 32'd31 << 22);
        fill_random();
        send(0, 31, 1'b1, 0, 1'b1);
        check("R9 wide not done", {31'h0, done_o}, 32'h0);
        send(31, 1, 1'b1, 0, 1'b1);
        check("R9 wide done", {31'h0, done_o}, 32'h1);
        check("R9 wide result", result_o, exp_result());
        check("R9 wide code", {8'h0, code_o}, {8'h0, exp_code()});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule